// File: doc/BRIEF.md
# Cumulative Throttle Dwell Timer

This block measures how long an active-low throttle pin has been held asserted, summed over any number of separate episodes, and presents the total as an 8-bit value. The pin is first passed through a two-stage synchronizer. While the synchronized pin is asserted, the block counts pulses of a periodic timebase strobe (one pulse is nominally 25 ms). While the pin is negated, counting pauses and the value is held. It resumes from the held value when the pin is asserted again.

The value is not a plain count. A value of 1 means only that at least one assertion has been seen. Once the asserted time passes two timebase periods, the value jumps to 2. From then on, every further asserted timebase pulse adds one, and the count stops at 255. A read strobe from the surrounding register bus clears the value and the limit flag. If the pin is asserted when the read happens, the value is set straight back to 1 and the time count starts again from nothing.

The value is compared with a programmable limit. When it is strictly greater than the limit, a sticky flag is set. An alert request is raised from that flag unless a mask input suppresses it.

Top module: `throttle_dwell_timer`

## Requirements
- R1: After reset, `dwell_val` is 0x00 and both `over_limit` and `alert_req` are 0.
- R2: With `dwell_val` at 0x00, the first cycle in which the synchronized pin is asserted sets `dwell_val` to 0x01. This happens three clock edges after `throttle_n` falls: two synchronizer stages, then the value register.
- R3: While `dwell_val` is 0x01, it stays 0x01 for the first two asserted `tick` pulses. The third asserted pulse sets it to 0x02.
- R4: While `dwell_val` is between 0x02 and 0xFE, each `tick` pulse taken while the pin is asserted adds one.
- R5: While the synchronized pin is negated, `tick` pulses leave `dwell_val` unchanged. Counting continues from the held value after the next assertion.
- R6: At 0xFF, further asserted `tick` pulses leave `dwell_val` at 0xFF until a read.
- R7: A `rd_stb` pulse taken while the pin is negated sets `dwell_val` to 0x00 and clears `over_limit` at the same clock edge.
- R8: A `rd_stb` pulse taken while the pin is asserted sets `dwell_val` to 0x01. Reaching 0x02 then takes three fresh asserted `tick` pulses.
- R9: `over_limit` is set one clock edge after `dwell_val` exceeds `limit` (unsigned compare, strictly greater). It stays set until a read. A limit of 0x00 therefore flags on the first assertion, and 0x01 flags once the value reaches 0x02.
- R10: `alert_req` equals `over_limit` when `alert_mask` is 0 and is 0 when `alert_mask` is 1. The mask never stops `over_limit` from being set.
- R11: When `rd_stb` and `tick` arrive in the same cycle, the read wins. The tick is discarded, and if the pin is still asserted the value and time count restart as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| throttle_n | input | 1 | Asynchronous throttle pin, low means asserted |
| tick | input | 1 | One-cycle timebase pulse, one per dwell period |
| rd_stb | input | 1 | One-cycle strobe marking a bus read of the value |
| limit | input | 8 | Programmable limit compared with the value |
| alert_mask | input | 1 | 1 suppresses the alert request |
| dwell_val | output | 8 | Accumulated dwell value |
| over_limit | output | 1 | Sticky flag: value exceeded limit since last read |
| alert_req | output | 1 | Alert request, the flag gated by the mask |

## Verification
The read strobe and a timebase pulse can land on the same clock edge while the pin is asserted. In that case the clear, the immediate re-set to 0x01 and the restart of the time count all meet one pending increment. The bench provokes this by driving `rd_stb` and `tick` in the same cycle after two ticks have already been banked under a limit of 0x00. It then judges that the value reads 0x01, that the flag drops for exactly that edge and sets again one edge later, and that exactly three further ticks are needed to reach 0x02.

// File: rtl/dwell_pkg.sv
package dwell_pkg;

  // Coarse phase of the dwell value, derived from its code.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,   // value 0: nothing seen since clear
    PH_SEEN  = 2'd1,   // value 1: asserted, below the coarse threshold
    PH_TIMED = 2'd2    // value >= 2: coarse time count
  } dwell_phase_e;

  localparam int unsigned DEF_VAL_W     = 8;
  localparam int unsigned DEF_PRE_TICKS = 2;
  localparam int unsigned DEF_STAGES    = 2;

endpackage

// File: rtl/dwell_sync.sv
module dwell_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/dwell_core.sv
module dwell_core
  import dwell_pkg::*;
#(
  parameter int unsigned VAL_W     = DEF_VAL_W,
  parameter int unsigned PRE_TICKS = DEF_PRE_TICKS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             rd_stb,
  output logic [VAL_W-1:0] val
);

  localparam int unsigned PRE_W        = $clog2(PRE_TICKS + 1);
  localparam logic [VAL_W-1:0] VAL_ZERO = '0;
  localparam logic [VAL_W-1:0] VAL_ONE  = VAL_W'(1);
  localparam logic [VAL_W-1:0] VAL_TWO  = VAL_W'(2);
  localparam logic [VAL_W-1:0] VAL_MAX  = '1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_TICKS);

  logic [VAL_W-1:0] val_q, val_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             upd_en;
  dwell_phase_e     phase;

  always_comb begin
    if (val_q == VAL_ZERO) begin
      phase = PH_IDLE;
    end else if (val_q == VAL_ONE) begin
      phase = PH_SEEN;
    end else begin
      phase = PH_TIMED;
    end
  end

  // State only moves on a read or while the pin is asserted.
  assign upd_en = rd_stb | active;

  always_comb begin
    val_d = val_q;
    pre_d = pre_q;
    if (rd_stb) begin
      // Read wins over any tick in the same cycle.
      pre_d = '0;
      val_d = active ? VAL_ONE : VAL_ZERO;
    end else if (active) begin
      unique case (phase)
        PH_IDLE: begin
          val_d = VAL_ONE;
          pre_d = tick ? PRE_W'(1) : '0;
        end
        PH_SEEN: begin
          if (tick) begin
            if (pre_q == PRE_LAST) begin
              val_d = VAL_TWO;
              pre_d = '0;
            end else begin
              pre_d = pre_q + PRE_W'(1);
            end
          end
        end
        default: begin
          if (tick && (val_q != VAL_MAX)) begin
            val_d = val_q + VAL_ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      pre_q <= '0;
    end else if (upd_en) begin
      val_q <= val_d;
      pre_q <= pre_d;
    end
  end

  assign val = val_q;

endmodule

// File: rtl/dwell_limit.sv
module dwell_limit #(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] val,
  input  logic [VAL_W-1:0] limit,
  input  logic             rd_stb,
  input  logic             mask,
  output logic             flag,
  output logic             alert
);

  logic flag_q, flag_d;
  logic exceed;

  assign exceed = (val > limit);

  always_comb begin
    if (rd_stb) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q | exceed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag  = flag_q;
  assign alert = flag_q & ~mask;

endmodule

// File: rtl/throttle_dwell_timer.sv
module throttle_dwell_timer
  import dwell_pkg::*;
#(
  parameter int unsigned VAL_W     = DEF_VAL_W,
  parameter int unsigned PRE_TICKS = DEF_PRE_TICKS,
  parameter int unsigned STAGES    = DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             throttle_n,
  input  logic             tick,
  input  logic             rd_stb,
  input  logic [VAL_W-1:0] limit,
  input  logic             alert_mask,
  output logic [VAL_W-1:0] dwell_val,
  output logic             over_limit,
  output logic             alert_req
);

  logic rst_sync_n;
  logic pin_sync_n;
  logic active;

  // Reset: asserted asynchronously, released through a synchronizer.
  dwell_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (rst_sync_n)
  );

  // Throttle pin: idles high (negated) out of reset.
  dwell_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .d      (throttle_n),
    .q      (pin_sync_n)
  );

  assign active = ~pin_sync_n;

  dwell_core #(.VAL_W(VAL_W), .PRE_TICKS(PRE_TICKS)) u_core (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .active (active),
    .tick   (tick),
    .rd_stb (rd_stb),
    .val    (dwell_val)
  );

  dwell_limit #(.VAL_W(VAL_W)) u_limit (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .val    (dwell_val),
    .limit  (limit),
    .rd_stb (rd_stb),
    .mask   (alert_mask),
    .flag   (over_limit),
    .alert  (alert_req)
  );

endmodule

// File: rtl/throttle_dwell_timer_chk.sv
module throttle_dwell_timer_chk #(
  parameter int unsigned VAL_W = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             active,
  input logic             tick,
  input logic             rd_stb,
  input logic [VAL_W-1:0] limit,
  input logic             alert_mask,
  input logic [VAL_W-1:0] dwell_val,
  input logic             over_limit,
  input logic             alert_req
);

  localparam logic [VAL_W-1:0] VMAX = '1;
  localparam logic [VAL_W-1:0] VONE = VAL_W'(1);

  p_pause_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!active && !rd_stb) |=> $stable(dwell_val));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active && tick && !rd_stb && dwell_val >= VAL_W'(2) && dwell_val != VMAX)
      |=> dwell_val == $past(dwell_val) + VONE);

  p_hold_sat_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dwell_val == VMAX && !rd_stb) |=> dwell_val == VMAX);

  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stb && !active) |=> (dwell_val == '0 && !over_limit));

  p_rd_rearm_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stb && active) |=> dwell_val == VONE);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dwell_val > limit && !rd_stb) |=> over_limit);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (over_limit && !rd_stb) |=> over_limit);

  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    alert_req |-> (over_limit && !alert_mask));

endmodule

bind throttle_dwell_timer throttle_dwell_timer_chk #(.VAL_W(VAL_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .active     (active),
  .tick       (tick),
  .rd_stb     (rd_stb),
  .limit      (limit),
  .alert_mask (alert_mask),
  .dwell_val  (dwell_val),
  .over_limit (over_limit),
  .alert_req  (alert_req)
);

// File: tb/throttle_dwell_timer_bench.sv
`timescale 1ns/1ps
module throttle_dwell_timer_bench;

  logic       clk;
  logic       rst_n;
  logic       throttle_n;
  logic       tick;
  logic       rd_stb;
  logic [7:0] limit;
  logic       alert_mask;
  logic [7:0] dwell_val;
  logic       over_limit;
  logic       alert_req;

  int n_vec;
  int n_bad;
  bit done;

  throttle_dwell_timer u_throttle_dwell_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .throttle_n (throttle_n),
    .tick       (tick),
    .rd_stb     (rd_stb),
    .limit      (limit),
    .alert_mask (alert_mask),
    .dwell_val  (dwell_val),
    .over_limit (over_limit),
    .alert_req  (alert_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; throttle_n = 1'b1; tick = 1'b0; rd_stb = 1'b0;
    limit = 8'hFF; alert_mask = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Drive pin, then wait until the value register has seen it.
  task automatic set_pin(input logic lvl);
    throttle_n = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 value after reset", dwell_val, 8'h00);
    chk("R1 flag after reset", {7'd0, over_limit}, 8'h00);
    chk("R1 alert after reset", {7'd0, alert_req}, 8'h00);
  endtask

  task automatic t_first_and_coarse();
    do_reset();
    pulse_tick(2);
    chk("R5 ticks while idle", dwell_val, 8'h00);
    throttle_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 not yet through sync", dwell_val, 8'h00);
    @(negedge clk);
    chk("R2 first assertion", dwell_val, 8'h01);
    pulse_tick(2);
    chk("R3 two ticks stay 1", dwell_val, 8'h01);
    pulse_tick(1);
    chk("R3 third tick gives 2", dwell_val, 8'h02);
    pulse_tick(1);
    chk("R4 step to 3", dwell_val, 8'h03);
    pulse_tick(4);
    chk("R4 step to 7", dwell_val, 8'h07);
  endtask

  task automatic t_pause_resume();
    do_reset();
    set_pin(1'b0);
    pulse_tick(3);
    set_pin(1'b1);
    pulse_tick(5);
    chk("R5 held while negated", dwell_val, 8'h02);
    set_pin(1'b0);
    chk("R5 reassert keeps value", dwell_val, 8'h02);
    pulse_tick(2);
    chk("R5 resumed count", dwell_val, 8'h04);
  endtask

  task automatic t_saturate();
    do_reset();
    set_pin(1'b0);
    pulse_tick(256);
    chk("R6 reaches full scale", dwell_val, 8'hFF);
    pulse_tick(5);
    chk("R6 holds full scale", dwell_val, 8'hFF);
    chk("R9 limit FF never exceeded", {7'd0, over_limit}, 8'h00);
  endtask

  task automatic t_reads();
    do_reset();
    limit = 8'h01;
    set_pin(1'b0);
    pulse_tick(5);
    @(negedge clk);
    chk("R9 flag at value 4 limit 1", {7'd0, over_limit}, 8'h01);
    set_pin(1'b1);
    pulse_read();
    chk("R7 read clears value", dwell_val, 8'h00);
    chk("R7 read clears flag", {7'd0, over_limit}, 8'h00);
    set_pin(1'b0);
    pulse_tick(4);
    chk("R8 setup value 3", dwell_val, 8'h03);
    pulse_read();
    chk("R8 read during assertion gives 1", dwell_val, 8'h01);
    pulse_tick(2);
    chk("R8 restart two ticks", dwell_val, 8'h01);
    pulse_tick(1);
    chk("R8 restart third tick", dwell_val, 8'h02);
  endtask

  task automatic t_limit_mask();
    do_reset();
    limit = 8'h01;
    set_pin(1'b0);
    @(negedge clk);
    chk("R9 value 1 not over limit 1", {7'd0, over_limit}, 8'h00);
    pulse_tick(3);
    @(negedge clk);
    chk("R9 value 2 over limit 1", {7'd0, over_limit}, 8'h01);
    chk("R10 alert unmasked", {7'd0, alert_req}, 8'h01);
    alert_mask = 1'b1;
    #1;
    chk("R10 alert masked", {7'd0, alert_req}, 8'h00);
    set_pin(1'b1);
    pulse_read();
    limit = 8'h00;
    set_pin(1'b0);
    @(negedge clk);
    chk("R9 limit 0 flags on first assertion", {7'd0, over_limit}, 8'h01);
    chk("R10 mask keeps flag, no alert", {7'd0, alert_req}, 8'h00);
  endtask

  task automatic t_collision();
    do_reset();
    limit = 8'h00;
    set_pin(1'b0);
    pulse_tick(2);
    rd_stb = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    tick = 1'b0;
    chk("R11 read wins over tick", dwell_val, 8'h01);
    chk("R11 flag cleared at read edge", {7'd0, over_limit}, 8'h00);
    @(negedge clk);
    chk("R11 flag relatched", {7'd0, over_limit}, 8'h01);
    pulse_tick(2);
    chk("R11 tick discarded", dwell_val, 8'h01);
    pulse_tick(1);
    chk("R11 third fresh tick", dwell_val, 8'h02);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; throttle_n = 1'b1; tick = 1'b0; rd_stb = 1'b0;
    limit = 8'hFF; alert_mask = 1'b0;
    t_reset();
    t_first_and_coarse();
    t_pause_resume();
    t_saturate();
    t_reads();
    t_limit_mask();
    t_collision();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule